// File: doc/BRIEF.md
# Processor-local countdown timer

This block is the timer of a processor's local interrupt controller. Software programs a timer entry (vector, mask, mode), a divide setting and an initial count through a small register port. The block then counts a free-running base tick input. When the count runs out it raises a single-cycle interrupt request that carries the programmed vector. Prioritising, queueing and delivering that request to the core are left to the logic downstream.

Writing the initial count records that moment as the start of the run. Every later expiry is derived from the divided ticks counted since that start, so in periodic mode the requests sit on a fixed grid of multiples of (count + 1) divided ticks. The grid does not drift, and masking the timer never shifts it. The current-count register shows how far the present period has progressed.

Top module: `core_countdown_timer`

## Requirements
- R1: After reset, offset 0 reads 0x0001_0000 (masked, one-shot, vector 0), offsets 1, 2 and 3 read 0, and until the divide register is first written each base tick counts as one divided tick.
- R2: Register offsets: 0 is the timer entry (vector in bits 7:0, mask in bit 16, periodic select in bit 17), 1 is the initial count, 2 is the divide setting (bits 3:0 stored), and 3 is the current count. Offset 3 is read-only and ignores writes.
- R3: The divide code {bit3, bit1, bit0} selects a divide of 2^(code+1) for codes 0 to 6 and a divide of 1 for code 7.
- R4: In one-shot mode with count N>0 and divide D, exactly one request follows the (N+1)·D-th base tick after the count write. After that the timer is idle and offset 3 reads 0 until the count is written again.
- R5: In periodic mode with count N>0, a request follows every base tick whose index k since the count write is a multiple of (N+1)·D.
- R6: An initial count of 0 stops the timer in either mode. It raises no request and offset 3 reads 0.
- R7: While the mask bit is set, no request is raised, but counting goes on. After the mask is cleared, requests resume on the same grid as before.
- R8: A request is high for exactly one clock, in the clock after the expiring tick, and irq_vec then equals the programmed vector.
- R9: Offset 3 reads N minus the number of divided ticks elapsed in the current period.
- R10: If the initial count is written in the same clock as an expiring tick, no request is raised and the timer restarts from the new count.
- R11: A base tick that arrives in the same clock as a write of the initial count is not counted toward the new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Base time tick, one clock wide per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_req | output | 1 | One-clock timer interrupt request |
| irq_vec | output | 8 | Vector that goes with irq_req |

## Verification
Two events can fall in the same clock: the tick that ends a period, and a rewrite of the initial count. The bench reproduces this by running its own model of the tick index. It issues the count write in exactly the clock whose tick would expire, and it expects the write to win: no request, and a fresh run whose first expiry lands (N+1)·D ticks later. The same model judges the tick that shares a clock with any count write. Across the sweep over every divide code, both modes and several counts, it predicts the request and the current count in every clock.

// File: rtl/core_countdown_timer.sv
module core_countdown_timer #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int PRE_W = 7;
  localparam int SH_W  = 3;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  logic [VEC_W-1:0] vec;
  logic             masked, periodic;
  logic [CNT_W-1:0] init_cnt, cur;
  logic [3:0]       div_cfg;
  logic [SH_W-1:0]  shift;
  logic [PRE_W-1:0] pre;
  logic             running;

  wire wr_entry = reg_wr && (reg_addr == 2'd0);
  wire wr_init  = reg_wr && (reg_addr == 2'd1);
  wire wr_div   = reg_wr && (reg_addr == 2'd2);

  wire [PRE_W:0]   one_sh   = (PRE_W+1)'(1) << shift;
  wire [PRE_W-1:0] pre_mask = PRE_W'(one_sh - 1'b1);
  wire div_step = base_tick && ((pre & pre_mask) == pre_mask);
  wire expire   = running && div_step && (cur == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec      <= '0;
      masked   <= 1'b1;
      periodic <= 1'b0;
      div_cfg  <= '0;
      shift    <= '0;
    end else begin
      if (wr_entry) begin
        vec      <= reg_wdata[VEC_W-1:0];
        masked   <= reg_wdata[MASK_BIT];
        periodic <= reg_wdata[PER_BIT];
      end
      if (wr_div) begin
        div_cfg <= reg_wdata[3:0];
        shift   <= {reg_wdata[3], reg_wdata[1:0]} + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_cnt <= '0;
      cur      <= '0;
      pre      <= '0;
      running  <= 1'b0;
    end else if (wr_init) begin
      init_cnt <= reg_wdata[CNT_W-1:0];
      cur      <= reg_wdata[CNT_W-1:0];
      pre      <= '0;
      running  <= (reg_wdata[CNT_W-1:0] != '0);
    end else begin
      if (base_tick) pre <= pre + 1'b1;
      if (running && div_step) begin
        if (cur == '0) begin
          if (periodic) cur <= init_cnt;
          else running <= 1'b0;
        end else begin
          cur <= cur - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= expire && !masked && !wr_init;
      if (expire && !masked && !wr_init) irq_vec <= vec;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[VEC_W-1:0] = vec;
        reg_rdata[MASK_BIT]  = masked;
        reg_rdata[PER_BIT]   = periodic;
      end
      2'd1: reg_rdata[CNT_W-1:0] = init_cnt;
      2'd2: reg_rdata[3:0] = div_cfg;
      default: reg_rdata[CNT_W-1:0] = running ? cur : '0;
    endcase
  end
endmodule

// File: rtl/core_countdown_timer_chk.sv
module core_countdown_timer_chk #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [VEC_W-1:0] vec,
  input logic             masked,
  input logic             periodic,
  input logic             running,
  input logic [CNT_W-1:0] init_cnt
);
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  a_r8_vector_match: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec == $past(vec));
  a_r7_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(masked));
  a_r6_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(init_cnt) != '0);
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(reg_wr && reg_addr == 2'd1));
  a_r4_oneshot_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !$past(periodic)) |-> !running);
endmodule

bind core_countdown_timer core_countdown_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .irq_req(irq_req), .irq_vec(irq_vec), .vec(vec), .masked(masked),
  .periodic(periodic), .running(running), .init_cnt(init_cnt)
);

// File: tb/sim_core_countdown_timer.sv
module sim_core_countdown_timer;
  logic clk = 1'b0, rst_n = 1'b0, base_tick = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;

  core_countdown_timer u0 (.clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int k = 0, N = 0, D = 1;
  bit act = 0, mk = 1, per = 0;
  logic [7:0] vec_m = '0;

  task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, act_v, exp_v, cyc);
    end
  endtask

  function automatic int dec(input logic [31:0] d);
    int c = {d[3], d[1:0]};
    return (c == 7) ? 1 : (2 << c);
  endfunction

  function automatic bit tpat();
    return (cyc % 4) != 3;
  endfunction

  function automatic bit would_hit(input bit tk);
    int k1 = k + 1;
    return act && tk && (k1 % D == 0) && (((k1 / D) % (N + 1)) == 0);
  endfunction

  task automatic step(input bit tk, input bit wr, input logic [1:0] a,
                      input logic [31:0] d, input string tag);
    bit hit, exp_p;
    longint exp_c;
    @(negedge clk);
    base_tick = tk; reg_wr = wr; reg_addr = wr ? a : 2'd3; reg_wdata = d;
    hit = would_hit(tk);
    exp_p = hit && !mk && !(wr && a == 2'd1);
    if (wr && a == 2'd1) begin N = int'(d); k = 0; act = (d != 0); end
    else if (act && tk) begin k = k + 1; if (hit && !per) act = 0; end
    if (wr && a == 2'd0) begin vec_m = d[7:0]; mk = d[16]; per = d[17]; end
    if (wr && a == 2'd2) D = dec(d);
    @(posedge clk);
    #1;
    cyc++;
    chk(irq_req == exp_p, {tag, " request (R8)"}, irq_req, exp_p);
    if (exp_p) chk(irq_vec == vec_m, "R8 vector", irq_vec, vec_m);
    if (!wr) begin
      exp_c = act ? (N - ((k / D) % (N + 1))) : 0;
      chk(reg_rdata == exp_c, {tag, " current count (R9)"}, reg_rdata, exp_c);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tpat(), 0, 2'd0, '0, tag);
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_wr = 0; reg_addr = a; base_tick = 0;
    #1;
    chk(reg_rdata == e, tag, reg_rdata, e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, 32'h0001_0000, "R1 entry reset");
    rd(2'd1, 32'h0, "R1 count reset");
    rd(2'd2, 32'h0, "R1 divide reset");
    rd(2'd3, 32'h0, "R1 current reset");
    step(1, 1, 2'd0, 32'h0002_0011, "R2");
    rd(2'd0, 32'h0002_0011, "R2 entry readback");
    step(1, 1, 2'd1, 32'd2, "R1 divide-by-1 R11");
    run(14, "R1 R5");
    step(1, 1, 2'd3, 32'h1234, "R2 read-only");
    run(6, "R2");
    rd(2'd1, 32'd2, "R2 count readback");
    step(0, 1, 2'd1, 32'd0, "R6");
    for (int code = 0; code < 8; code++) begin
      for (int n = 1; n <= 3; n++) begin
        for (int p = 0; p < 2; p++) begin
          logic [31:0] dv;
          dv = {28'd0, code[2], 1'b0, code[1:0]};
          step(tpat(), 1, 2'd0, {14'd0, p[0], 1'b0, 8'd0, 8'(8'h40 + code * 8 + n * 2 + p)}, "R2");
          step(tpat(), 1, 2'd2, dv, "R3");
          rd(2'd2, dv, "R3 divide readback");
          step(tpat(), 1, 2'd1, n, "R11");
          run((3 * (n + 1) * dec(dv) + 2) * 4 / 3 + 4, p ? "R3 R5" : "R3 R4");
          step(tpat(), 1, 2'd1, 32'd0, "R6");
        end
      end
    end
    step(1, 1, 2'd2, 32'h0000_000b, "R3");
    step(1, 1, 2'd0, 32'h0003_0077, "R7");
    step(1, 1, 2'd1, 32'd2, "R7");
    run(12, "R7 masked");
    step(tpat(), 1, 2'd0, 32'h0002_0077, "R7 unmask");
    run(16, "R7 resumed");
    step(1, 1, 2'd0, 32'h0002_0055, "R6");
    step(1, 1, 2'd1, 32'd0, "R6");
    run(40, "R6 periodic zero");
    step(1, 1, 2'd0, 32'h0000_0055, "R6");
    run(40, "R6 one-shot zero");
    step(1, 1, 2'd0, 32'h0002_0066, "R10");
    step(1, 1, 2'd1, 32'd3, "R10");
    for (int i = 0; i < 40; i++) begin
      if (would_hit(tpat())) begin
        step(tpat(), 1, 2'd1, 32'd3, "R10 collision");
        break;
      end
      step(tpat(), 0, 2'd0, '0, "R10");
    end
    run(20, "R10 R11 restart");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule